// File: doc/BRIEF.md
# Transmit Deferral and Interframe Gap Timer

This block decides when a half-duplex Ethernet transmitter may begin a new frame. A restart pulse starts a new deferral: either the transmitter reports that a frame has ended, or the backoff logic reports that its wait is over. The block first waits for carrier sense to drop. It then counts bit times, using a one-cycle bit-time enable, until the full interframe gap has passed. After that it raises a transmit-permit level. The permit holds until the transmitter reports that a frame has started.

The gap is split into two windows. Carrier seen in the early window means the medium is busy again, so the timer goes back to waiting for an idle medium. Carrier seen in the late window is ignored, and the transmitter starts on time even though a collision may follow. A full-duplex input makes the timer ignore carrier completely and enforce only the gap length. A separate receive-side monitor counts idle bit times between received frames. It pulses a flag when a new frame arrives after a gap shorter than the guaranteed minimum.

Top module: `ifg_defer_timer`

## Requirements
- R1: After reset, tx_permit and rx_short_gap are low and the timer is waiting for an idle medium.
- R2: After a restart pulse (tx_done or backoff_done, which act in any state), gap counting does not begin while crs is high in half-duplex mode. The first gap tick counts only from the clock cycle after crs is sampled low.
- R3: With no carrier during the gap, tx_permit rises in the cycle after the 96th counted bit tick, and not before.
- R4: If crs is high in a cycle after fewer than 60 gap ticks have been counted, the gap is abandoned. A full 96-tick gap is then needed once crs falls again.
- R5: If crs is high after 60 or more gap ticks have been counted, it is ignored and tx_permit still rises after the 96th tick.
- R6: Clock cycles without bit_tick do not advance any gap or receive-gap count.
- R7: With full_duplex high, crs has no effect, and tx_permit rises 96 ticks after the restart.
- R8: Once high, tx_permit stays high until tx_start is sampled. It is low from the following cycle and stays low until the next restart and its gap have completed.
- R9: A tx_start pulse while tx_permit is low is ignored and does not change when the permit arrives.
- R10: When rx_dv rises after at least one earlier received frame, rx_short_gap pulses for exactly one cycle if fewer than 28 bit ticks were counted while rx_dv was low. It stays low if 28 or more were counted, and it stays low for the first frame after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable, one per bit time |
| full_duplex | input | 1 | Ignore carrier sense when high |
| crs | input | 1 | Carrier sense |
| tx_done | input | 1 | Pulse: a transmitted frame has ended |
| backoff_done | input | 1 | Pulse: a backoff wait has ended |
| tx_start | input | 1 | Pulse: the transmitter is starting a frame |
| rx_dv | input | 1 | Receive frame in progress |
| tx_permit | output | 1 | Transmission may start |
| rx_short_gap | output | 1 | One-cycle pulse: receive gap below the guaranteed minimum |

## Verification
The transmit side is swept over every position of a single carrier burst within the 96-tick gap, from tick 0 to tick 95. This separates the restart window from the ignore window exactly at the 59/60 boundary, and it checks that the permit never arrives a tick early or late. Ticks are spaced with idle cycles, and a run of tick-free cycles is added, so that a counter running on the clock instead of the enable would fail. Full-duplex runs hold carrier high throughout, and stray start pulses are sent during the gap. The receive monitor is swept over gap lengths from 0 to 40 ticks, which brackets the 27/28 boundary, and it is also tried on the first frame after reset.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

   typedef enum logic [2:0] {
      DF_WAIT_IDLE = 3'd0,
      DF_GAP_EARLY = 3'd1,
      DF_GAP_LATE  = 3'd2,
      DF_PERMIT    = 3'd3,
      DF_BUSY      = 3'd4
   } defer_state_t;

   function automatic int cnt_width(input int max_value);
      return (max_value < 2) ? 1 : $clog2(max_value + 1);
   endfunction

endpackage

// File: rtl/bit_time_counter.sv
module bit_time_counter #(
   parameter int MAX_COUNT = 95,
   parameter bit SATURATE  = 1'b0,
   localparam int W = ifg_pkg::cnt_width(MAX_COUNT)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] LIMIT = W'(MAX_COUNT);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_next;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_next = cnt_q;
            if (inc && cnt_q != LIMIT) cnt_next = cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            cnt_next = cnt_q;
            if (inc) cnt_next = (cnt_q == LIMIT) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else               cnt_q <= cnt_next;
   end

   assign count = cnt_q;

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   // R6
   no_idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tx_defer_fsm.sv
module tx_defer_fsm #(
   parameter int GAP_BITS   = 96,
   parameter int GUARD_BITS = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic full_duplex,
   input  logic crs,
   input  logic restart,
   input  logic tx_start,
   output logic tx_permit
);
   import ifg_pkg::*;

   localparam int W = cnt_width(GAP_BITS - 1);
   localparam logic [W-1:0] LAST_TICK  = W'(GAP_BITS - 1);
   localparam logic [W-1:0] GUARD_LAST = W'(GUARD_BITS - 1);

   defer_state_t st_q, st_d;
   logic [W-1:0] gap_cnt;
   logic         in_gap;
   logic         busy_medium;

   assign in_gap      = (st_q == DF_GAP_EARLY) || (st_q == DF_GAP_LATE);
   assign busy_medium = crs && !full_duplex;

   bit_time_counter #(
      .MAX_COUNT (GAP_BITS - 1),
      .SATURATE  (1'b0)
   ) u_gap_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_gap),
      .inc   (in_gap && bit_tick),
      .count (gap_cnt)
   );

   always_comb begin
      st_d = st_q;
      if (restart) begin
         st_d = DF_WAIT_IDLE;
      end else begin
         unique case (st_q)
            DF_WAIT_IDLE: if (!busy_medium) st_d = DF_GAP_EARLY;
            DF_GAP_EARLY: begin
               if (busy_medium)                             st_d = DF_WAIT_IDLE;
               else if (bit_tick && gap_cnt == GUARD_LAST)  st_d = DF_GAP_LATE;
            end
            DF_GAP_LATE:  if (bit_tick && gap_cnt == LAST_TICK) st_d = DF_PERMIT;
            DF_PERMIT:    if (tx_start) st_d = DF_BUSY;
            DF_BUSY:      st_d = DF_BUSY;
            default:      st_d = DF_WAIT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= DF_WAIT_IDLE;
      else        st_q <= st_d;
   end

   assign tx_permit = (st_q == DF_PERMIT);

   // R3
   permit_after_full_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_permit) |-> ($past(gap_cnt) == LAST_TICK && $past(bit_tick)));

   // R4
   early_carrier_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == DF_GAP_EARLY && crs && !full_duplex) |=> st_q == DF_WAIT_IDLE);

   // R5
   late_carrier_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == DF_GAP_LATE && !restart) |=> (st_q == DF_GAP_LATE || st_q == DF_PERMIT));

   // R7
   duplex_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == DF_WAIT_IDLE && full_duplex && !restart) |=> st_q == DF_GAP_EARLY);

   // R8
   permit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_permit && !tx_start && !restart) |=> tx_permit);

   // R8
   permit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_permit && tx_start) |=> !tx_permit);

endmodule

// File: rtl/rx_gap_monitor.sv
module rx_gap_monitor #(
   parameter int MIN_GAP = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic rx_dv,
   output logic short_gap
);
   import ifg_pkg::*;

   localparam int W = cnt_width(MIN_GAP);
   localparam logic [W-1:0] MIN_CNT = W'(MIN_GAP);

   logic [W-1:0] idle_cnt;
   logic         dv_q;
   logic         seen_frame_q;
   logic         frame_rise;
   logic         flag_q;

   bit_time_counter #(
      .MAX_COUNT (MIN_GAP),
      .SATURATE  (1'b1)
   ) u_idle_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_dv),
      .inc   (!rx_dv && bit_tick),
      .count (idle_cnt)
   );

   assign frame_rise = rx_dv && !dv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dv_q         <= 1'b0;
         seen_frame_q <= 1'b0;
         flag_q       <= 1'b0;
      end else begin
         dv_q   <= rx_dv;
         flag_q <= frame_rise && seen_frame_q && (idle_cnt < MIN_CNT);
         if (rx_dv) seen_frame_q <= 1'b1;
      end
   end

   assign short_gap = flag_q;

   // R10
   flag_on_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_gap |-> ($past(rx_dv) && !$past(dv_q)));

   // R10
   flag_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_gap |=> !short_gap);

endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer #(
   parameter int GAP_BITS   = 96,
   parameter int GUARD_BITS = 60,
   parameter int RX_MIN_GAP = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic full_duplex,
   input  logic crs,
   input  logic tx_done,
   input  logic backoff_done,
   input  logic tx_start,
   input  logic rx_dv,
   output logic tx_permit,
   output logic rx_short_gap
);

   initial begin
      gap_len_chk: assert (GAP_BITS >= 2)
         else $error("GAP_BITS must be at least 2");
      guard_len_chk: assert (GUARD_BITS >= 1 && GUARD_BITS < GAP_BITS)
         else $error("GUARD_BITS must lie in 1..GAP_BITS-1");
      rx_gap_len_chk: assert (RX_MIN_GAP >= 1)
         else $error("RX_MIN_GAP must be at least 1");
   end

   logic restart;
   assign restart = tx_done || backoff_done;

   tx_defer_fsm #(
      .GAP_BITS   (GAP_BITS),
      .GUARD_BITS (GUARD_BITS)
   ) u_tx_defer (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .full_duplex (full_duplex),
      .crs         (crs),
      .restart     (restart),
      .tx_start    (tx_start),
      .tx_permit   (tx_permit)
   );

   rx_gap_monitor #(
      .MIN_GAP (RX_MIN_GAP)
   ) u_rx_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .rx_dv     (rx_dv),
      .short_gap (rx_short_gap)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!tx_permit && !rx_short_gap));

   // R2
   restart_drops_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tx_permit);

endmodule

// File: tb/tb_ifg_defer_timer.sv
module tb_ifg_defer_timer;

   localparam int GAP   = 96;
   localparam int GUARD = 60;
   localparam int RXMIN = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic full_duplex = 1'b0;
   logic crs = 1'b0;
   logic tx_done = 1'b0;
   logic backoff_done = 1'b0;
   logic tx_start = 1'b0;
   logic rx_dv = 1'b0;
   logic tx_permit;
   logic rx_short_gap;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ifg_defer_timer dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_tick     (bit_tick),
      .full_duplex  (full_duplex),
      .crs          (crs),
      .tx_done      (tx_done),
      .backoff_done (backoff_done),
      .tx_start     (tx_start),
      .rx_dv        (rx_dv),
      .tx_permit    (tx_permit),
      .rx_short_gap (rx_short_gap)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic t);
      bit_tick = t;
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(1'b1);
         cyc(1'b0);
      end
   endtask

   task automatic restart_tx(input logic use_backoff);
      if (use_backoff) backoff_done = 1'b1;
      else             tx_done      = 1'b1;
      cyc(1'b0);
      tx_done      = 1'b0;
      backoff_done = 1'b0;
   endtask

   initial begin
      #(8ns * 200000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc(1'b0);
      cyc(1'b0);
      // R1: reset state
      chk(tx_permit, 1'b0, "R1 permit at reset");
      chk(rx_short_gap, 1'b0, "R1 flag at reset");
      rst_n = 1'b1;
      crs = 1'b1;
      cyc(1'b0);
      tick_n(GAP + 5);
      // R1: still waiting for idle medium while carrier high
      chk(tx_permit, 1'b0, "R1 waits for idle");

      // R10: first frame after reset is never flagged
      rx_dv = 1'b1;
      cyc(1'b0);
      chk(rx_short_gap, 1'b0, "R10 first frame not flagged");

      // sweep carrier burst position k over the whole gap
      for (int k = 0; k < GAP; k++) begin
         crs = 1'b1;
         restart_tx(k[0]);
         tick_n(3);
         // R2: no counting while carrier high
         chk(tx_permit, 1'b0, "R2 carrier holds deferral");
         crs = 1'b0;
         cyc(1'b0);
         tick_n(k);
         crs = 1'b1;
         cyc(1'b0);
         crs = 1'b0;
         cyc(1'b0);
         if (k < GUARD) begin
            tick_n(GAP - 1);
            // R4: early carrier restarts the full gap
            chk(tx_permit, 1'b0, "R4 no permit before full restart gap");
            tick_n(1);
            chk(tx_permit, 1'b1, "R4 permit after full restart gap");
         end else begin
            tick_n(GAP - k - 1);
            // R5: late carrier ignored
            chk(tx_permit, 1'b0, "R5 no permit before tick 96");
            tick_n(1);
            chk(tx_permit, 1'b1, "R5 permit at tick 96");
         end
         if (k % 16 == 0) begin
            for (int j = 0; j < 10; j++) cyc(1'b0);
            // R8: permit holds without start
            chk(tx_permit, 1'b1, "R8 permit holds");
            crs = 1'b1;
            tick_n(3);
            chk(tx_permit, 1'b1, "R8 permit holds under carrier");
            crs = 1'b0;
         end
         tx_start = 1'b1;
         cyc(1'b0);
         tx_start = 1'b0;
         chk(tx_permit, 1'b0, "R8 permit drops after start");
         tick_n(GAP + 2);
         chk(tx_permit, 1'b0, "R8 stays low until restart");
      end

      // R3 and R6: exact count with long tick-free stretches
      crs = 1'b0;
      restart_tx(1'b0);
      cyc(1'b0);
      tick_n(GAP - 1);
      for (int j = 0; j < 40; j++) cyc(1'b0);
      chk(tx_permit, 1'b0, "R6 idle cycles do not count");
      tick_n(1);
      chk(tx_permit, 1'b1, "R3 permit after 96 ticks");
      tx_start = 1'b1;
      cyc(1'b0);
      tx_start = 1'b0;

      // R9: stray start during gap ignored
      restart_tx(1'b1);
      cyc(1'b0);
      tick_n(30);
      tx_start = 1'b1;
      cyc(1'b0);
      tx_start = 1'b0;
      tick_n(GAP - 31);
      chk(tx_permit, 1'b0, "R9 stray start no early permit");
      tick_n(1);
      chk(tx_permit, 1'b1, "R9 permit on time after stray start");
      tx_start = 1'b1;
      cyc(1'b0);
      tx_start = 1'b0;

      // R7: full duplex ignores carrier
      full_duplex = 1'b1;
      crs = 1'b1;
      restart_tx(1'b0);
      cyc(1'b0);
      tick_n(GAP - 1);
      chk(tx_permit, 1'b0, "R7 full duplex no early permit");
      tick_n(1);
      chk(tx_permit, 1'b1, "R7 full duplex permit under carrier");
      tx_start = 1'b1;
      cyc(1'b0);
      tx_start = 1'b0;
      full_duplex = 1'b0;
      crs = 1'b0;

      // R10: receive gap sweep
      for (int g = 0; g <= 40; g++) begin
         rx_dv = 1'b1;
         tick_n(2);
         rx_dv = 1'b0;
         cyc(1'b0);
         tick_n(g);
         for (int j = 0; j < 5; j++) cyc(1'b0);
         chk(rx_short_gap, 1'b0, "R10 no flag during gap");
         rx_dv = 1'b1;
         cyc(1'b0);
         chk(rx_short_gap, (g < RXMIN) ? 1'b1 : 1'b0, $sformatf("R10 gap %0d", g));
         cyc(1'b0);
         chk(rx_short_gap, 1'b0, "R10 single pulse");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule